// File: doc/BRIEF.md
# Bus Access Fault Classifier

The block sits in front of a memory map and judges every bus request in the cycle it arrives. It decodes the address into a region (code flash, RAM, a row of 4 KB peripheral windows, a block of system peripherals) and checks the request against that region. The checks cover transfer size, word alignment, the privilege of a write and whether the address lands on anything implemented. Each illegal request is held back from the downstream bus and answered with an error. The reasons are collected in a sticky status word.

The status word records every cause that a request triggers, so several bits can be set by one request. A further overflow bit marks a fault that arrives while earlier causes are still pending. Software reads the word through a small register port and clears bits by writing ones. A one-cycle pulse accompanies every faulting request so that fault-handling logic can react.

The peripheral count, the number of implemented registers in each peripheral, the system-peripheral mask and the sizes of flash, RAM, protected RAM and the system block are all parameters.

Top module: `bus_fault_classifier`

## Requirements
- R1: `req_size_i` encodes 0 = byte, 1 = halfword, 2 = word. A byte or halfword request to the peripheral region (addr[31:28] = 4) sets status bit 0 (size), whether it reads or writes.
- R2: A word request whose addr[1:0] is not zero sets status bit 0 in any region. Byte and halfword requests outside the peripheral region do not set it.
- R3: A write with `req_priv_i` low sets status bit 1 (protection) when it targets any of three places: a peripheral whose bit in `APB_SYS` is set, the system block (addr[31:28] = 5), or RAM below offset `PROT_RAM_BYTES`. Unprivileged reads and privileged writes to these places do not set it.
- R4: In the peripheral region, addr[27:12] selects the peripheral and addr[11:2] selects the register word. Status bit 2 (reserved) is set when the peripheral index is `NUM_APB` or more, or when the word index is at or above that peripheral's `APB_NREG` entry.
- R5: Status bit 2 is also set in several cases: a flash offset (addr[31:28] = 0) at or above `FLASH_BYTES`, a RAM offset (addr[31:28] = 2) at or above `RAM_BYTES`, a system-block offset at or above `AHB_BYTES`, and any other value of addr[31:28].
- R6: One request sets every cause bit whose condition holds, all in the same update.
- R7: A faulting request that arrives while any status bit is already set also sets status bit 3 (missed). A fault with the status all clear leaves bit 3 at zero.
- R8: Status bits stay set until software clears them. A register-port write clears exactly the bits written as 1. When a clear and a fault land in the same cycle, the new fault bits win.
- R9: `fault_o` is high for exactly one cycle, in the cycle after each faulting request, and low otherwise.
- R10: A faulting request gives `dn_valid_o` low, `rsp_err_o` high and `rsp_rdata_o` zero in the same cycle. A legal request gives `dn_valid_o` high with `rsp_rdata_o` equal to `dn_rdata_i`.
- R11: After reset the status reads zero and `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Request byte address |
| req_write_i | input | 1 | 1 = write |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_priv_i | input | 1 | 1 = privileged |
| req_wdata_i | input | 32 | Write data |
| rsp_err_o | output | 1 | Error response for this request |
| rsp_rdata_o | output | 32 | Read data, zero on error |
| dn_valid_o | output | 1 | Request forwarded downstream |
| dn_addr_o | output | 32 | Forwarded address |
| dn_write_o | output | 1 | Forwarded direction |
| dn_size_o | output | 2 | Forwarded size |
| dn_wdata_o | output | 32 | Forwarded write data |
| dn_rdata_i | input | 32 | Downstream read data |
| csr_we_i | input | 1 | Status write strobe (write 1 to clear) |
| csr_wdata_i | input | 4 | Bits to clear |
| csr_rdata_o | output | 4 | Status: bit0 size, bit1 protection, bit2 reserved, bit3 missed |
| fault_o | output | 1 | One-cycle fault pulse |

## Verification
The bench builds the block with four peripherals. Their register counts are 8, 1, 16 and 4, and peripherals 0 and 2 are marked as system. A single-register peripheral makes the upper edge of a register window sit one word in. The mixed system mask puts a protected and an unprotected peripheral next to each other. With 64 KB flash, 8 KB RAM, 1 KB protected RAM and a 4 KB system block, the last legal word and the first illegal word of every region can be reached with short literal addresses. Those values also allow requests that raise all three causes at once.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
  typedef enum logic [2:0] {RG_FLASH, RG_RAM, RG_APB, RG_AHB, RG_NONE} region_e;
  localparam int ST_SIZE = 0;
  localparam int ST_PROT = 1;
  localparam int ST_RESV = 2;
  localparam int ST_MISS = 3;
  localparam int ST_W    = 4;
  localparam int CAUSE_W = 3;
endpackage

// File: rtl/bfc_region.sv
module bfc_region
  import bfc_pkg::*;
#(
  parameter int unsigned NUM_APB = 4,
  parameter int unsigned APB_NREG [NUM_APB] = '{8, 1, 16, 4},
  parameter logic [NUM_APB-1:0] APB_SYS = 4'b0101,
  parameter int unsigned FLASH_BYTES = 32'h0001_0000,
  parameter int unsigned RAM_BYTES = 32'h0000_2000,
  parameter int unsigned PROT_RAM_BYTES = 32'h0000_0400,
  parameter int unsigned AHB_BYTES = 32'h0000_1000
) (
  input  logic [31:0] addr_i,
  output region_e     region_o,
  output logic        resv_o,
  output logic        sys_o
);
  localparam int IDX_W = 16;
  localparam int WRD_W = 10;

  logic [31:0]      offs;
  logic [IDX_W-1:0] idx;
  logic [WRD_W-1:0] wrd;
  logic             hit;
  int unsigned      nreg;

  assign offs = {4'h0, addr_i[27:0]};
  assign idx  = addr_i[27:12];
  assign wrd  = addr_i[11:2];

  always_comb begin
    region_o = RG_NONE;
    resv_o   = 1'b0;
    sys_o    = 1'b0;
    hit      = 1'b0;
    nreg     = 0;
    for (int i = 0; i < int'(NUM_APB); i++) begin
      if (idx == IDX_W'(i)) begin
        hit  = 1'b1;
        nreg = APB_NREG[i];
      end
    end
    unique case (addr_i[31:28])
      4'h0: begin
        region_o = RG_FLASH;
        resv_o   = offs >= FLASH_BYTES;
      end
      4'h2: begin
        region_o = RG_RAM;
        resv_o   = offs >= RAM_BYTES;
        sys_o    = offs < PROT_RAM_BYTES;
      end
      4'h4: begin
        region_o = RG_APB;
        resv_o   = !hit || ({22'h0, wrd} >= nreg);
        for (int i = 0; i < int'(NUM_APB); i++)
          if (idx == IDX_W'(i)) sys_o = APB_SYS[i];
      end
      4'h5: begin
        region_o = RG_AHB;
        resv_o   = offs >= AHB_BYTES;
        sys_o    = 1'b1;
      end
      default: resv_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bfc_rules.sv
module bfc_rules
  import bfc_pkg::*;
(
  input  region_e              region_i,
  input  logic                 resv_i,
  input  logic                 sys_i,
  input  logic [1:0]           addr_lo_i,
  input  size_e                size_i,
  input  logic                 write_i,
  input  logic                 priv_i,
  output logic [CAUSE_W-1:0]   cause_o
);
  always_comb begin
    cause_o          = '0;
    cause_o[ST_SIZE] = (region_i == RG_APB && size_i != SZ_WORD) ||
                       (size_i == SZ_WORD && addr_lo_i != 2'b00);
    cause_o[ST_PROT] = write_i && !priv_i && sys_i;
    cause_o[ST_RESV] = resv_i;
  end
endmodule

// File: rtl/bfc_status.sv
module bfc_status
  import bfc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fault_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_we_i,
  input  logic [ST_W-1:0]    clr_mask_i,
  output logic [ST_W-1:0]    stat_o,
  output logic               pulse_o
);
  logic [ST_W-1:0] stat_q, stat_d, kept, setv;

  always_comb begin
    kept = clr_we_i ? (stat_q & ~clr_mask_i) : stat_q;
    setv = fault_i ? {|stat_q, cause_i} : '0;
    stat_d = kept | setv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      pulse_o <= fault_i;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/bus_fault_classifier.sv
module bus_fault_classifier
  import bfc_pkg::*;
#(
  parameter int unsigned NUM_APB = 4,
  parameter int unsigned APB_NREG [NUM_APB] = '{8, 1, 16, 4},
  parameter logic [NUM_APB-1:0] APB_SYS = 4'b0101,
  parameter int unsigned FLASH_BYTES = 32'h0001_0000,
  parameter int unsigned RAM_BYTES = 32'h0000_2000,
  parameter int unsigned PROT_RAM_BYTES = 32'h0000_0400,
  parameter int unsigned AHB_BYTES = 32'h0000_1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_addr_i,
  input  logic        req_write_i,
  input  logic [1:0]  req_size_i,
  input  logic        req_priv_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_err_o,
  output logic [31:0] rsp_rdata_o,
  output logic        dn_valid_o,
  output logic [31:0] dn_addr_o,
  output logic        dn_write_o,
  output logic [1:0]  dn_size_o,
  output logic [31:0] dn_wdata_o,
  input  logic [31:0] dn_rdata_i,
  input  logic        csr_we_i,
  input  logic [3:0]  csr_wdata_i,
  output logic [3:0]  csr_rdata_o,
  output logic        fault_o
);
  region_e            region;
  logic               resv, sys_tgt, fault;
  logic [CAUSE_W-1:0] cause;

  bfc_region #(
    .NUM_APB(NUM_APB), .APB_NREG(APB_NREG), .APB_SYS(APB_SYS),
    .FLASH_BYTES(FLASH_BYTES), .RAM_BYTES(RAM_BYTES),
    .PROT_RAM_BYTES(PROT_RAM_BYTES), .AHB_BYTES(AHB_BYTES)
  ) i_region (
    .addr_i(req_addr_i), .region_o(region), .resv_o(resv), .sys_o(sys_tgt)
  );

  bfc_rules i_rules (
    .region_i(region), .resv_i(resv), .sys_i(sys_tgt),
    .addr_lo_i(req_addr_i[1:0]), .size_i(size_e'(req_size_i)),
    .write_i(req_write_i), .priv_i(req_priv_i), .cause_o(cause)
  );

  assign fault = req_valid_i && (|cause);

  bfc_status i_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault), .cause_i(cause),
    .clr_we_i(csr_we_i), .clr_mask_i(csr_wdata_i),
    .stat_o(csr_rdata_o), .pulse_o(fault_o)
  );

  // illegal requests never reach the downstream bus
  assign dn_valid_o  = req_valid_i && !fault;
  assign dn_addr_o   = req_addr_i;
  assign dn_write_o  = req_write_i;
  assign dn_size_o   = req_size_i;
  assign dn_wdata_o  = req_wdata_i;
  assign rsp_err_o   = fault;
  assign rsp_rdata_o = fault ? 32'h0 : dn_rdata_i;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_addr_i,
  input logic [1:0]  req_size_i,
  input logic        rsp_err_o,
  input logic [31:0] rsp_rdata_o,
  input logic        dn_valid_o,
  input logic        csr_we_i,
  input logic [3:0]  csr_rdata_o,
  input logic        fault_o
);
  // R10
  err_blocks_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !dn_valid_o);
  // R10
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_rdata_o == 32'h0);
  // R9
  pulse_after_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rsp_err_o) |=> fault_o);
  // R9
  no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && rsp_err_o) |=> !fault_o);
  // R7
  missed_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rsp_err_o && csr_rdata_o != 4'h0) |=> csr_rdata_o[3]);
  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && !(req_valid_i && rsp_err_o)) |=> $stable(csr_rdata_o));
  // R1
  apb_subword_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[31:28] == 4'h4 && req_size_i != 2'd2) |-> rsp_err_o);
endmodule

bind bus_fault_classifier bfc_checker i_bfc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_addr_i(req_addr_i), .req_size_i(req_size_i), .rsp_err_o(rsp_err_o),
  .rsp_rdata_o(rsp_rdata_o), .dn_valid_o(dn_valid_o), .csr_we_i(csr_we_i),
  .csr_rdata_o(csr_rdata_o), .fault_o(fault_o)
);

// File: tb/test_bus_fault_classifier.sv
`timescale 1ns/1ps
module test_bus_fault_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, dn_rdata = '0;
  logic [1:0]  req_size = '0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_wdata = '0;
  logic        rsp_err, dn_valid, dn_write, fault;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata;
  logic [1:0]  dn_size;
  logic [3:0]  csr_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bus_fault_classifier #(
    .NUM_APB(4), .APB_NREG('{8, 1, 16, 4}), .APB_SYS(4'b0101),
    .FLASH_BYTES(32'h1_0000), .RAM_BYTES(32'h2000),
    .PROT_RAM_BYTES(32'h400), .AHB_BYTES(32'h1000)
  ) i_bus_fault_classifier (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_size_i(req_size), .req_priv_i(req_priv),
    .req_wdata_i(req_wdata), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .dn_valid_o(dn_valid), .dn_addr_o(dn_addr), .dn_write_o(dn_write),
    .dn_size_o(dn_size), .dn_wdata_o(dn_wdata), .dn_rdata_i(dn_rdata),
    .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .fault_o(fault)
  );

  // {addr, write, size, priv, expected causes {resv, prot, size}}
  localparam int NV = 25;
  localparam logic [38:0] VEC [NV] = '{
    {32'h4000_0000, 1'b0, 2'd2, 1'b1, 3'b000},
    {32'h4000_0000, 1'b0, 2'd0, 1'b1, 3'b001},
    {32'h4000_1000, 1'b1, 2'd1, 1'b0, 3'b001},
    {32'h4000_0002, 1'b0, 2'd2, 1'b1, 3'b001},
    {32'h4000_0004, 1'b1, 2'd2, 1'b0, 3'b010},
    {32'h4000_0004, 1'b1, 2'd2, 1'b1, 3'b000},
    {32'h4000_0004, 1'b0, 2'd2, 1'b0, 3'b000},
    {32'h4000_0020, 1'b0, 2'd2, 1'b1, 3'b100},
    {32'h4000_001C, 1'b0, 2'd2, 1'b1, 3'b000},
    {32'h4000_1004, 1'b0, 2'd2, 1'b1, 3'b100},
    {32'h4000_4000, 1'b0, 2'd2, 1'b1, 3'b100},
    {32'h4000_0021, 1'b1, 2'd0, 1'b0, 3'b111},
    {32'h2000_0100, 1'b1, 2'd2, 1'b0, 3'b010},
    {32'h2000_0400, 1'b1, 2'd2, 1'b0, 3'b000},
    {32'h2000_2000, 1'b0, 2'd2, 1'b1, 3'b100},
    {32'h2000_1FFC, 1'b0, 2'd2, 1'b0, 3'b000},
    {32'h0000_FFFC, 1'b0, 2'd2, 1'b0, 3'b000},
    {32'h0001_0000, 1'b0, 2'd2, 1'b0, 3'b100},
    {32'h0000_0001, 1'b0, 2'd0, 1'b0, 3'b000},
    {32'h5000_0010, 1'b1, 2'd2, 1'b0, 3'b010},
    {32'h5000_1000, 1'b0, 2'd2, 1'b1, 3'b100},
    {32'h7000_0000, 1'b0, 2'd2, 1'b1, 3'b100},
    {32'h0000_0002, 1'b0, 2'd1, 1'b0, 3'b000},
    {32'h2000_0003, 1'b1, 2'd2, 1'b0, 3'b011},
    {32'h4000_2040, 1'b1, 2'd1, 1'b0, 3'b111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear(input logic [3:0] mask);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = mask;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  // drive a request for one cycle; check same-cycle response, then next-cycle state
  task automatic access(input logic [31:0] a, input logic w, input logic [1:0] s,
                        input logic p, input logic exp_err, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_size = s; req_priv = p;
    #1;
    check({req, " err"}, 32'(rsp_err), 32'(exp_err));
    check({req, " fwd"}, 32'(dn_valid), 32'(!exp_err));
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " pulse"}, 32'(fault), 32'(exp_err));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check("R11 reset status", 32'(csr_rdata), 32'h0);
    check("R11 reset pulse", 32'(fault), 32'h0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    check("R11 status after release", 32'(csr_rdata), 32'h0);

    // R1 R2 R3 R4 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      clear(4'hF);
      access(v[38:7], v[6], v[5:4], v[3], |v[2:0], $sformatf("R1-R6 vec%0d", i));
      check($sformatf("R6 causes vec%0d", i), 32'(csr_rdata), {28'h0, 1'b0, v[2:0]});
      @(negedge clk);
      check($sformatf("R9 pulse one cycle vec%0d", i), 32'(fault), 32'h0);
    end

    // R7 missed on second fault
    clear(4'hF);
    access(32'h4000_0000, 1'b0, 2'd0, 1'b1, 1'b1, "R7 first");
    check("R7 first no missed", 32'(csr_rdata), 32'h1);
    access(32'h7000_0000, 1'b0, 2'd2, 1'b1, 1'b1, "R7 second");
    check("R7 missed set", 32'(csr_rdata), 32'hD);
    // R8 legal access leaves status alone
    access(32'h2000_0800, 1'b1, 2'd2, 1'b0, 1'b0, "R8 legal");
    check("R8 sticky", 32'(csr_rdata), 32'hD);
    // R8 partial clear
    clear(4'b0001);
    check("R8 partial clear", 32'(csr_rdata), 32'hC);
    clear(4'b1000);
    check("R8 clear missed", 32'(csr_rdata), 32'h4);
    // R8 set wins over clear in the same cycle; R7 uses prior status
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h4000_0004; req_write = 1'b1;
    req_size = 2'd2; req_priv = 1'b0;
    csr_we = 1'b1; csr_wdata = 4'hF;
    @(negedge clk);
    req_valid = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    check("R8 set wins over clear", 32'(csr_rdata), 32'hA);

    // R10 read data path
    clear(4'hF);
    @(negedge clk);
    dn_rdata = 32'hDEAD_BEEF;
    req_valid = 1'b1; req_addr = 32'h2000_0010; req_write = 1'b0;
    req_size = 2'd2; req_priv = 1'b0;
    #1;
    check("R10 legal read data", rsp_rdata, 32'hDEAD_BEEF);
    check("R10 legal forward", 32'(dn_valid), 32'h1);
    req_addr = 32'h2000_4000;
    #1;
    check("R10 fault read data zero", rsp_rdata, 32'h0);
    check("R10 fault blocked", 32'(dn_valid), 32'h0);
    @(negedge clk);
    req_valid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule